// File: doc/BRIEF.md
# Triggered Multi-Channel Waveform Capture Ring

This block records free-running sample streams from several converter channels into one ring memory per channel. While the block is armed, each channel stores one sample on every clock. Once a ring is full, each new sample replaces the oldest one, so each ring always holds the most recent history of its channel.

A trigger pulse freezes all rings in the same clock. The block then raises an interrupt request and a busy line that other boards can observe. A host drains the frozen traces through a valid/ready read port. It reads one enabled channel after another, and each trace comes out from the oldest sample to the newest. When every enabled trace has been read, a host acknowledge re-arms capture.

A busy input from other boards gates writing and triggering. This lets several boards start and stop acquisition together.

Top module: `wave_capture`

## Requirements
- R1: While armed, with `busy_in` low and `trig_in` low, every channel stores the sample on its slice of `smp_data` (channel c on bits c*SAMPLE_W upward) once per clock. Each ring keeps the last DEPTH stored samples, and the oldest is overwritten first.
- R2: `trig_in` high while armed with `busy_in` low freezes all rings in that clock. The sample present in the trigger cycle is not stored.
- R3: After reset, `irq`, `busy_out` and `rd_valid` are low. `irq` and `busy_out` go high in the cycle after an accepted trigger and stay high until re-arm.
- R4: While `busy_in` is high, no sample is stored and `trig_in` is ignored.
- R5: `trig_in` pulses while frozen are ignored. They change neither the traces nor the point where each trace starts.
- R6: `ch_mask` bit c enables channel c. The mask is taken in the trigger cycle. Readout delivers enabled channels only, in ascending index, with the index on `rd_chan`. An all-zero mask delivers no words.
- R7: Each delivered channel gives exactly DEPTH words, from the oldest stored sample to the newest. `rd_last` is high on the final word of each channel.
- R8: A word transfers only when `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_valid`, `rd_data` and `rd_chan` hold.
- R9: `host_ack` is honoured only after all enabled words are read. An earlier acknowledge is ignored. An honoured acknowledge re-arms capture, and `irq` and `busy_out` are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | NUM_CH*SAMPLE_W | Packed samples, channel c on slice c |
| trig_in | input | 1 | Trigger, freezes all rings |
| busy_in | input | 1 | Busy from other boards, inhibits writing and triggering |
| ch_mask | input | NUM_CH | Channel enable mask for readout |
| rd_ready | input | 1 | Host ready for a read word |
| host_ack | input | 1 | Host acknowledge, re-arms capture |
| rd_valid | output | 1 | Read word available |
| rd_data | output | SAMPLE_W | Read sample |
| rd_chan | output | CH_W | Channel of the read word |
| rd_last | output | 1 | Final word of the current channel |
| irq | output | 1 | Interrupt request, traces ready |
| busy_out | output | 1 | Acquisition stopped, for other boards |

## Verification
A wrong write pointer or a missed freeze shows up on the first word read after a trigger. That word would be a sample other than the oldest one kept, or one captured after the trigger. A fault in the channel or word counter shows within one channel's drain, as a wrong `rd_chan`, a misplaced `rd_last` or a channel delivered that is not enabled. Gating faults shift the stored history, so they appear in the readout after the next trigger. Errors in the handshake or the acknowledge appear in the same cycle on `rd_valid`, `irq` or `busy_out`.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_READ  = 2'd1,
    ST_DONE  = 2'd2
  } wc_state_e;

  // address of the sample 'offset' places after 'base' in a ring of 'depth'
  function automatic int unsigned ring_addr(input int unsigned base,
                                            input int unsigned offset,
                                            input int unsigned depth);
    return (base + offset) % depth;
  endfunction

  // lowest set bit of mask at index >= start and < n; n when none
  function automatic int first_enabled(input logic [31:0] mask,
                                       input int start,
                                       input int n);
    int res;
    res = n;
    for (int i = 31; i >= 0; i--) begin
      if (i >= start && i < n && mask[i]) res = i;
    end
    return res;
  endfunction

endpackage

// File: rtl/wc_ring.sv
module wc_ring #(
  parameter int SAMPLE_W = 14,
  parameter int DEPTH    = 2048,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [SAMPLE_W-1:0] rd_data
);

  logic [SAMPLE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
  import wc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEPTH  = 2048,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              busy_in,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic              rd_ready,
  input  logic              host_ack,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  output logic [CW-1:0]     rd_chan,
  output logic              rd_valid,
  output logic              rd_last,
  output logic              irq,
  output logic              busy_out
);

  wc_state_e         state;
  logic [AW-1:0]     wp;
  logic [AW-1:0]     frz_ptr;
  logic [NUM_CH-1:0] mask_q;
  logic [CW-1:0]     ch_q;
  logic [AW-1:0]     cnt;

  // named internal events
  logic trig_acc;
  logic xfer;
  logic last_word;
  int   first_ch;
  int   next_ch;

  assign trig_acc  = (state == ST_ARMED) && !busy_in && trig_in;
  assign wr_en     = (state == ST_ARMED) && !busy_in && !trig_in;
  assign xfer      = rd_valid && rd_ready;
  assign last_word = (cnt == AW'(DEPTH - 1));
  assign first_ch  = first_enabled(32'(ch_mask), 0, NUM_CH);
  assign next_ch   = first_enabled(32'(mask_q), int'(ch_q) + 1, NUM_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_ARMED;
      wp      <= '0;
      frz_ptr <= '0;
      mask_q  <= '0;
      ch_q    <= '0;
      cnt     <= '0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (wr_en) wp <= AW'(ring_addr(int'(wp), 1, DEPTH));
          if (trig_acc) begin
            frz_ptr <= wp;
            mask_q  <= ch_mask;
            cnt     <= '0;
            if (first_ch == NUM_CH) begin
              state <= ST_DONE;
            end else begin
              ch_q  <= CW'(first_ch);
              state <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (xfer) begin
            if (last_word) begin
              cnt <= '0;
              if (next_ch == NUM_CH) state <= ST_DONE;
              else ch_q <= CW'(next_ch);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (host_ack) state <= ST_ARMED;
        end
        default: state <= ST_ARMED;
      endcase
    end
  end

  assign wr_addr  = wp;
  assign rd_addr  = AW'(ring_addr(int'(frz_ptr), int'(cnt), DEPTH));
  assign rd_chan  = ch_q;
  assign rd_valid = (state == ST_READ);
  assign rd_last  = rd_valid && last_word;
  assign irq      = (state != ST_ARMED);
  assign busy_out = (state != ST_ARMED);

  AST_TRIG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_acc |=> busy_out && $stable(wp));  // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !host_ack |=> irq);  // R3
  AST_BUSY_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |=> $stable(wp) && !$rose(busy_out));  // R4
  AST_FROZEN_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_out |=> $stable(wp) && $stable(frz_ptr));  // R5
  AST_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> irq);  // R9

endmodule

// File: rtl/wave_capture.sv
module wave_capture
  import wc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 14,
  parameter int DEPTH    = 2048,
  localparam int AW      = $clog2(DEPTH),
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
  input  logic                       trig_in,
  input  logic                       busy_in,
  input  logic [NUM_CH-1:0]          ch_mask,
  input  logic                       rd_ready,
  input  logic                       host_ack,
  output logic                       rd_valid,
  output logic [SAMPLE_W-1:0]        rd_data,
  output logic [CH_W-1:0]            rd_chan,
  output logic                       rd_last,
  output logic                       irq,
  output logic                       busy_out
);

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [SAMPLE_W-1:0] ring_q [NUM_CH];

  wc_ctrl #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .busy_in  (busy_in),
    .ch_mask  (ch_mask),
    .rd_ready (rd_ready),
    .host_ack (host_ack),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .rd_chan  (rd_chan),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .irq      (irq),
    .busy_out (busy_out)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ring
    wc_ring #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) i_ring (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (smp_data[c*SAMPLE_W +: SAMPLE_W]),
      .rd_addr (rd_addr),
      .rd_data (ring_q[c])
    );
  end

  assign rd_data = ring_q[rd_chan];

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_chan));  // R8
  AST_LAST_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid && busy_out);  // R7

endmodule

// File: tb/test_wave_capture.sv
module test_wave_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int SW     = 14;
  localparam int DEPTH  = 2048;
  localparam int CH_W   = 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                   rst_n;
  logic [NUM_CH*SW-1:0]   smp_data;
  logic                   trig_in, busy_in, rd_ready, host_ack;
  logic [NUM_CH-1:0]      ch_mask;
  logic                   rd_valid, rd_last, irq, busy_out;
  logic [SW-1:0]          rd_data;
  logic [CH_W-1:0]        rd_chan;

  wave_capture #(.NUM_CH(NUM_CH), .SAMPLE_W(SW), .DEPTH(DEPTH)) i_wave_capture (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .trig_in(trig_in),
    .busy_in(busy_in), .ch_mask(ch_mask), .rd_ready(rd_ready),
    .host_ack(host_ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_chan(rd_chan), .rd_last(rd_last), .irq(irq), .busy_out(busy_out)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "reset";

  // reference model: history queues, frozen snapshots, readout cursor
  int hist [NUM_CH][$];
  int snap [NUM_CH][$];
  int m_state = 0;  // 0 armed, 1 reading, 2 waiting for acknowledge
  int m_ch = 0;
  int m_cnt = 0;
  logic [NUM_CH-1:0] m_mask = '0;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase, what, act, exp);
    end
  endtask

  function automatic int next_en(logic [NUM_CH-1:0] m, int from);
    for (int i = from; i < NUM_CH; i++) if (m[i]) return i;
    return NUM_CH;
  endfunction

  task automatic model_edge();
    case (m_state)
      0: if (!busy_in) begin
        if (trig_in) begin
          for (int c = 0; c < NUM_CH; c++) snap[c] = hist[c];
          m_mask = ch_mask;
          m_cnt = 0;
          m_ch = next_en(m_mask, 0);
          m_state = (m_ch == NUM_CH) ? 2 : 1;
        end else begin
          for (int c = 0; c < NUM_CH; c++) begin
            hist[c].push_back(int'(smp_data[c*SW +: SW]));
            if (hist[c].size() > DEPTH) void'(hist[c].pop_front());
          end
        end
      end
      1: if (rd_ready) begin
        if (m_cnt == DEPTH - 1) begin
          m_cnt = 0;
          m_ch = next_en(m_mask, m_ch + 1);
          if (m_ch == NUM_CH) m_state = 2;
        end else m_cnt++;
      end
      default: if (host_ack) m_state = 0;
    endcase
  endtask

  task automatic compare();
    chk("R3", int'(irq), int'(m_state != 0), "irq");
    chk("R3", int'(busy_out), int'(m_state != 0), "busy_out");
    chk("R6", int'(rd_valid), int'(m_state == 1), "rd_valid");
    if (m_state == 1) begin
      chk("R6", int'(rd_chan), m_ch, "rd_chan");
      chk("R7", int'(rd_data), snap[m_ch][m_cnt], "rd_data");
      chk("R7", int'(rd_last), int'(m_cnt == DEPTH - 1), "rd_last");
    end
  endtask

  task automatic cycle();
    for (int c = 0; c < NUM_CH; c++)
      smp_data[c*SW +: SW] = SW'((cyc * 37 + c * 1001 + (cyc >> 5)) & 16'h3fff);
    @(posedge clk);
    model_edge();
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic capture(logic [NUM_CH-1:0] m);
    ch_mask = m;
    trig_in = 1'b1;
    cycle();
    trig_in = 1'b0;
    ch_mask = ~m;  // later mask changes must not matter
  endtask

  task automatic drain(int ready_pct, bit noise);
    while (m_state == 1) begin
      rd_ready = ($urandom % 100) < ready_pct;
      trig_in  = noise && (($urandom % 7) == 0);  // R5
      host_ack = noise && (($urandom % 9) == 0);  // R9 early ack
      cycle();
    end
    rd_ready = 1'b0; trig_in = 1'b0; host_ack = 1'b0;
  endtask

  task automatic ack();
    host_ack = 1'b1;
    cycle();
    host_ack = 1'b0;
    chk("R9", int'(irq), 0, "irq after ack");
    chk("R9", int'(busy_out), 0, "busy_out after ack");
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_data = '0; trig_in = 1'b0; busy_in = 1'b0;
    ch_mask = '0; rd_ready = 1'b0; host_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare();  // R3 reset state
    chk("R3", int'(rd_last), 0, "rd_last at reset");

    // R1 R2: plain fill, all channels, host always ready
    phase = "R1 R2 full capture";
    repeat (DEPTH + 13) cycle();
    capture(4'b1111);
    drain(100, 1'b0);
    ack();

    // R4: busy gating with triggers offered while busy
    phase = "R4 busy gating";
    repeat (700) begin
      busy_in = ($urandom % 3) == 0;
      trig_in = busy_in && (($urandom % 4) == 0);
      cycle();
    end
    busy_in = 1'b0; trig_in = 1'b0;
    // R5 R8 R9: sparse mask, stalls, stray triggers and early acks
    phase = "R5 R8 R9 stalled readout";
    capture(4'b0101);
    drain(45, 1'b1);
    ack();

    // R6: empty mask gives no words
    phase = "R6 empty mask";
    repeat (50) cycle();
    capture(4'b0000);
    chk("R6", int'(rd_valid), 0, "rd_valid with empty mask");
    cycle();
    ack();

    // R7 R8: single high channel with long stalls
    phase = "R7 R8 single channel";
    repeat (333) cycle();
    capture(4'b1000);
    rd_ready = 1'b0;
    repeat (5) cycle();
    drain(70, 1'b0);
    ack();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule